// File: doc/BRIEF.md
# Graphics Command Packet Framer

The framer takes a stream of 32-bit graphics command words and cuts it into whole command packets. The opcode in the top byte of a packet's first word selects a fixed word count, or for the two polyline families it selects a scan for a terminator word. Every accepted word goes into a circular word buffer. When the last word of a packet arrives, the framer emits one output beat that gives the opcode, the length in words, a class tag and the buffer slot of the first word. A downstream engine fetches the packet's words through a separate read port.

Environment-setting opcodes produce no packet. Each one writes its whole word into one of eight shadow registers, and a status output is built from two of those registers. Image-transfer and copy opcodes are tagged with their own class so that a separate path can take them. A packet that has only partly arrived stays in the buffer until its remaining words come in. A polyline that would outgrow the buffer is dropped, and a one-cycle overflow flag is raised.

Top module: `cmd_framer`

## Requirements
- R1: The opcode is bits 31:24 of a packet's first word. The packet length is 1 plus an extra-word count: 2 for 0x02; for 0x20-0x3F, in steps of four opcodes, 3, 6, 4, 8, 5, 8, 7, 11; 2 for 0xA0-0xDF; 3 for 0x80-0x9F.
- R2: For opcodes 0x48-0x4F, every word at index 3 or above (the first word is index 0) is tested. The packet ends at, and includes, the first such word for which (word & 0xF000F000) == 0x50005000. Terminator-shaped words at indices 1 and 2 do not end the packet.
- R3: For opcodes 0x58-0x5F, only words at even indices of 4 or above are tested with the same terminator rule. Terminator-shaped words at odd indices do not end the packet.
- R4: The pkt_kind output is 1 for opcodes 0xA0-0xBF (image write, 3 words), 2 for 0xC0-0xDF (image read, 3 words) and 3 for 0x80-0x9F (copy, 4 words). It is 0 for every other opcode.
- R5: A one-word packet with opcode 0xE0-0xE7 writes its whole word into shadow register (opcode & 7). It produces no output beat.
- R6: After reset, shadow register i holds (0xE0 + i) << 24. Status therefore reads 0, pkt_valid and overflow are low, and in_ready is high.
- R7: status[10:0] equals bits 10:0 of shadow register 1, and status[12:11] equals bits 1:0 of shadow register 6. Writes to any other shadow register leave status unchanged.
- R8: An incomplete packet is held. No beat appears, however long the input is idle, until the final word is accepted.
- R9: pkt_valid is high for exactly one cycle, in the cycle after the final word is accepted. The beat's pkt_ptr is the slot of the packet's first word. Accepted words occupy consecutive slots modulo the buffer depth, and rd_data returns the word stored at rd_addr.
- R10: If a word fills the buffer (a depth's worth of words) without ending its packet, overflow and a low in_ready appear for one cycle and no beat is emitted. The packet's slots are reused, and the next word starts a new packet.
- R11: The remaining opcodes take these lengths: 0x40-0x47 take 3, 0x50-0x57 take 4, 0x60-0x63 take 3, 0x64-0x67 take 4, 0x68-0x6B, 0x70-0x73 and 0x78-0x7B take 2, 0x74-0x77 and 0x7C-0x7F take 3. All others, 0x00 and 0xE8-0xFF among them, take 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Command word offered |
| in_data | input | 32 | Command word |
| in_ready | output | 1 | Word accepted when high together with in_valid |
| pkt_valid | output | 1 | One-cycle packet beat |
| pkt_opcode | output | 8 | Opcode of the packet |
| pkt_len | output | ADDR_W+1 | Packet length in words |
| pkt_kind | output | 2 | Class: 0 draw, 1 image write, 2 image read, 3 copy |
| pkt_ptr | output | ADDR_W | Buffer slot of the packet's first word |
| rd_addr | input | ADDR_W | Buffer read address |
| rd_data | output | 32 | Word stored at rd_addr |
| status | output | 13 | Status bits taken from the shadow registers |
| overflow | output | 1 | One-cycle pulse when a packet is dropped |

## Verification
The bench builds the framer with ADDR_W = 4, a 16-word buffer. At that depth an unterminated polyline reaches the overflow drop after sixteen words, and a polyline that ends exactly on the sixteenth word checks the boundary just short of the drop. The small depth also makes slot numbering wrap several times, so pointer continuity across the wrap and the reuse of a dropped packet's slots can both be checked from pkt_ptr and the read port.

// File: rtl/framer_pkg.sv
// Shared types and opcode decoding functions for the command packet framer.
// Assumes 8-bit opcodes taken from the top byte of a packet's first word.
package framer_pkg;

    typedef enum logic [1:0] {
        PK_DRAW   = 2'd0,
        PK_VWRITE = 2'd1,
        PK_VREAD  = 2'd2,
        PK_COPY   = 2'd3
    } pkt_kind_e;

    // Number of words after the first for fixed-length opcodes.
    function automatic logic [3:0] extra_words(input logic [7:0] op);
        logic [3:0] n;
        case (op[7:5])
            3'b000: n = (op == 8'h02) ? 4'd2 : 4'd0;
            3'b001: begin
                case (op[4:2])
                    3'd0: n = 4'd3;
                    3'd1: n = 4'd6;
                    3'd2: n = 4'd4;
                    3'd3: n = 4'd8;
                    3'd4: n = 4'd5;
                    3'd5: n = 4'd8;
                    3'd6: n = 4'd7;
                    default: n = 4'd11;
                endcase
            end
            3'b010: n = op[4] ? 4'd3 : 4'd2;
            3'b011: begin
                case (op[4:2])
                    3'd0: n = 4'd2;
                    3'd1: n = 4'd3;
                    3'd2: n = 4'd1;
                    3'd3: n = 4'd0;
                    3'd4: n = 4'd1;
                    3'd5: n = 4'd2;
                    3'd6: n = 4'd1;
                    default: n = 4'd2;
                endcase
            end
            3'b100: n = 4'd3;
            3'b101, 3'b110: n = 4'd2;
            default: n = 4'd0;
        endcase
        return n;
    endfunction

    // Class of a packet from its opcode.
    function automatic pkt_kind_e kind_of(input logic [7:0] op);
        case (op[7:5])
            3'b100:  return PK_COPY;
            3'b101:  return PK_VWRITE;
            3'b110:  return PK_VREAD;
            default: return PK_DRAW;
        endcase
    endfunction

endpackage

// File: rtl/framer_decode.sv
// Packet end detector: decides whether the word at index idx of a packet
// with opcode op is its last word. Purely combinational.
// Assumes idx counts from 0 at the opcode word.
module framer_decode
    import framer_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic [7:0]       op,
    input  logic [CNT_W-1:0] idx,
    input  logic [31:0]      word,
    output logic             done,
    output logic             is_env,
    output logic [1:0]       kind
);
    localparam logic [31:0] TERM_MASK = 32'hF000_F000;
    localparam logic [31:0] TERM_VAL  = 32'h5000_5000;

    logic poly_every;
    logic poly_pairs;
    logic term_hit;

    // Classify the opcode and test the word for the terminator shape.
    always_comb begin
        poly_every = (op[7:3] == 5'b01001);
        poly_pairs = (op[7:3] == 5'b01011);
        term_hit   = ((word & TERM_MASK) == TERM_VAL);
        is_env     = (op[7:3] == 5'b11100);
        kind       = kind_of(op);
        if (poly_every)
            done = term_hit && (idx >= CNT_W'(3));
        else if (poly_pairs)
            done = term_hit && (idx >= CNT_W'(4)) && !idx[0];
        else
            done = (idx == CNT_W'(extra_words(op)));
    end
endmodule

// File: rtl/framer_shadow.sv
// Eight environment shadow registers and the status bits derived from them.
// Assumes at most one write per cycle, selected by wr_idx.
module framer_shadow #(
    parameter int NREG = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [$clog2(NREG)-1:0] wr_idx,
    input  logic [31:0]             wr_data,
    output logic [12:0]             status
);
    localparam int IDX_W = $clog2(NREG);

    logic [31:0] shadow [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        // Load one shadow register; reset value carries its own opcode.
        always_ff @(posedge clk) begin
            if (!rst_n)
                shadow[g] <= 32'(32'hE0 + g) << 24;
            else if (wr_en && wr_idx == IDX_W'(g))
                shadow[g] <= wr_data;
        end
    end

    // Assemble status from the drawing-mode and mask registers.
    always_comb status = {shadow[6][1:0], shadow[1][10:0]};

    p_status_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IDX_W'(1)) |=> (status[10:0] == $past(wr_data[10:0])));

    p_status_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || (wr_idx != IDX_W'(1) && wr_idx != IDX_W'(6))) |=> $stable(status));
endmodule

// File: rtl/framer_buffer.sv
// Circular word store: one write port, one asynchronous read port.
// Assumes the depth is a power of two; contents are not reset.
module framer_buffer #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [31:0] mem [DEPTH];

    // Store each accepted word at its slot.
    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_addr] <= wr_data;
    end

    // Read any slot combinationally.
    always_comb rd_data = mem[rd_addr];

    p_write_visible_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_addr != $past(wr_addr) || rd_data == $past(wr_data)));
endmodule

// File: rtl/cmd_framer.sv
// Command packet framer top: accepts words, stores them, and emits one beat
// per complete packet; environment opcodes go to the shadow registers.
// Assumes ADDR_W >= 4 so that the longest fixed packet (12 words) fits.
module cmd_framer
    import framer_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       in_data,
    output logic              in_ready,
    output logic              pkt_valid,
    output logic [7:0]        pkt_opcode,
    output logic [ADDR_W:0]   pkt_len,
    output logic [1:0]        pkt_kind,
    output logic [ADDR_W-1:0] pkt_ptr,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    output logic [12:0]       status,
    output logic              overflow
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int CNT_W = ADDR_W + 1;

    logic              accept;
    logic              flush_q;
    logic [CNT_W-1:0]  count;
    logic [ADDR_W-1:0] start_ptr;
    logic [7:0]        op_q;
    logic [7:0]        cur_op;
    logic [ADDR_W-1:0] wr_addr;
    logic              done;
    logic              is_env;
    logic [1:0]        kind;
    logic              last_slot;

    // Handshake and per-word context of the packet being assembled.
    always_comb begin
        in_ready  = !flush_q;
        accept    = in_valid && in_ready;
        cur_op    = (count == '0) ? in_data[31:24] : op_q;
        wr_addr   = start_ptr + count[ADDR_W-1:0];
        last_slot = (count == CNT_W'(DEPTH - 1));
    end

    framer_decode #(.CNT_W(CNT_W)) i_decode (
        .op     (cur_op),
        .idx    (count),
        .word   (in_data),
        .done   (done),
        .is_env (is_env),
        .kind   (kind)
    );

    framer_buffer #(.ADDR_W(ADDR_W)) i_buffer (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (accept),
        .wr_addr (wr_addr),
        .wr_data (in_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    framer_shadow #(.NREG(8)) i_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (accept && done && is_env),
        .wr_idx  (cur_op[2:0]),
        .wr_data (in_data),
        .status  (status)
    );

    // Track packet progress, emit beats and drop oversized packets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count      <= '0;
            start_ptr  <= '0;
            op_q       <= '0;
            flush_q    <= 1'b0;
            overflow   <= 1'b0;
            pkt_valid  <= 1'b0;
            pkt_opcode <= '0;
            pkt_len    <= '0;
            pkt_kind   <= '0;
            pkt_ptr    <= '0;
        end else begin
            pkt_valid <= 1'b0;
            overflow  <= 1'b0;
            flush_q   <= 1'b0;
            if (accept) begin
                if (count == '0)
                    op_q <= in_data[31:24];
                if (done) begin
                    count     <= '0;
                    start_ptr <= start_ptr + count[ADDR_W-1:0] + ADDR_W'(1);
                    if (!is_env) begin
                        pkt_valid  <= 1'b1;
                        pkt_opcode <= cur_op;
                        pkt_len    <= count + CNT_W'(1);
                        pkt_kind   <= kind;
                        pkt_ptr    <= start_ptr;
                    end
                end else if (last_slot) begin
                    count    <= '0;
                    overflow <= 1'b1;
                    flush_q  <= 1'b1;
                end else begin
                    count <= count + CNT_W'(1);
                end
            end
        end
    end

    p_env_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && count == '0 && in_data[31:27] == 5'b11100) |=> !pkt_valid);

    p_beat_after_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> $past(accept));

    p_len_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> (pkt_len != '0 && pkt_len <= CNT_W'(DEPTH)));

    p_copy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_kind == PK_COPY) |-> (pkt_len == CNT_W'(4)));

    p_image_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && (pkt_kind == PK_VREAD || pkt_kind == PK_VWRITE)) |-> (pkt_len == CNT_W'(3)));

    p_drop_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> !pkt_valid);
endmodule

// File: tb/test_cmd_framer.sv
// Directed bench for the command packet framer, built with a 16-word buffer.
module test_cmd_framer;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [31:0]   in_data = '0;
    logic          in_ready;
    logic          pkt_valid;
    logic [7:0]    pkt_opcode;
    logic [AW:0]   pkt_len;
    logic [1:0]    pkt_kind;
    logic [AW-1:0] pkt_ptr;
    logic [AW-1:0] rd_addr = '0;
    logic [31:0]   rd_data;
    logic [12:0]   status;
    logic          overflow;

    int checks = 0;
    int errors = 0;
    int exp_ptr = 0;
    bit finished = 0;

    int          n_pkt = 0;
    int          n_ovf = 0;
    logic [7:0]  m_op;
    logic [AW:0] m_len;
    logic [1:0]  m_kind;
    logic [AW-1:0] m_ptr;
    logic        m_ovf_ready;

    cmd_framer #(.ADDR_W(AW)) i_cmd_framer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .pkt_valid(pkt_valid), .pkt_opcode(pkt_opcode),
        .pkt_len(pkt_len), .pkt_kind(pkt_kind), .pkt_ptr(pkt_ptr),
        .rd_addr(rd_addr), .rd_data(rd_data), .status(status), .overflow(overflow)
    );

    always #2.5 clk = ~clk;

    // Record packet beats and overflow pulses as they appear.
    always @(posedge clk) begin
        if (rst_n && pkt_valid) begin
            n_pkt  = n_pkt + 1;
            m_op   = pkt_opcode;
            m_len  = pkt_len;
            m_kind = pkt_kind;
            m_ptr  = pkt_ptr;
        end
        if (rst_n && overflow) begin
            n_ovf       = n_ovf + 1;
            m_ovf_ready = in_ready;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Offer one word and wait until it is taken.
    task automatic send_word(input logic [31:0] w);
        in_valid = 1'b1;
        in_data  = w;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic settle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic read_slot(input int slot, output logic [31:0] w);
        rd_addr = AW'(slot % DEPTH);
        #1;
        w = rd_data;
    endtask

    // Check the beat of the last packet against expectations and the buffer.
    task automatic expect_beat(input string tag, input int base, input logic [7:0] op,
                               input int len, input int kind,
                               input logic [31:0] first, input logic [31:0] last);
        logic [31:0] w;
        chk({tag, " beat count"}, n_pkt, base + 1);
        chk({tag, " opcode"}, m_op, op);
        chk({tag, " length"}, m_len, len);
        chk({tag, " kind"}, m_kind, kind);
        chk({tag, " pointer R9"}, m_ptr, exp_ptr % DEPTH);
        read_slot(exp_ptr, w);
        chk({tag, " first word R9"}, w, first);
        read_slot(exp_ptr + len - 1, w);
        chk({tag, " last word R9"}, w, last);
        exp_ptr = (exp_ptr + len) % DEPTH;
    endtask

    // Send a fixed-length packet with filler words and check its beat.
    task automatic fixed_pkt(input string tag, input logic [7:0] op, input int len, input int kind);
        int base = n_pkt;
        logic [31:0] first = {op, 24'h00_0123};
        logic [31:0] last = first;
        send_word(first);
        for (int i = 1; i < len; i++) begin
            last = 32'h0000_1000 + i;
            send_word(last);
        end
        settle();
        expect_beat(tag, base, op, len, kind, first, last);
    endtask

    task automatic t_reset();
        chk("R6 status after reset", status, 0);
        chk("R6 pkt_valid after reset", pkt_valid, 0);
        chk("R6 overflow after reset", overflow, 0);
        chk("R6 in_ready after reset", in_ready, 1);
    endtask

    task automatic t_fixed();
        fixed_pkt("R1 op20", 8'h20, 4, 0);
        fixed_pkt("R1 op2C", 8'h2C, 9, 0);
        fixed_pkt("R1 op3C", 8'h3C, 12, 0);
        fixed_pkt("R1 op02", 8'h02, 3, 0);
        fixed_pkt("R1 op35", 8'h35, 9, 0);
    endtask

    task automatic t_partial();
        int base = n_pkt;
        send_word(32'h2C00_0000);
        for (int i = 1; i < 5; i++) send_word(32'h0000_1000 + i);
        repeat (6) @(negedge clk);
        chk("R8 no beat while partial", n_pkt, base);
        for (int i = 5; i < 9; i++) send_word(32'h0000_1000 + i);
        settle();
        expect_beat("R8 resumed op2C", base, 8'h2C, 9, 0, 32'h2C00_0000, 32'h0000_1008);
    endtask

    task automatic t_poly_every();
        int base = n_pkt;
        send_word(32'h4800_0000);
        send_word(32'h5000_5000);
        send_word(32'h5555_5555);
        settle();
        chk("R2 early terminators ignored", n_pkt, base);
        send_word(32'h1234_1234);
        send_word(32'h5ABC_5DEF);
        settle();
        expect_beat("R2 op48", base, 8'h48, 5, 0, 32'h4800_0000, 32'h5ABC_5DEF);
    endtask

    task automatic t_poly_pairs();
        int base = n_pkt;
        send_word(32'h5A00_0000);
        for (int i = 1; i < 5; i++) send_word(32'h0000_1000 + i);
        send_word(32'h5111_5111);
        settle();
        chk("R3 odd-index terminator ignored", n_pkt, base);
        send_word(32'h5222_5222);
        settle();
        expect_beat("R3 op5A", base, 8'h5A, 7, 0, 32'h5A00_0000, 32'h5222_5222);
    endtask

    task automatic t_routes();
        fixed_pkt("R4 image write", 8'hA0, 3, 1);
        fixed_pkt("R4 image read", 8'hC5, 3, 2);
        fixed_pkt("R4 copy", 8'h80, 4, 3);
        fixed_pkt("R4 image read top", 8'hDF, 3, 2);
    endtask

    task automatic t_env();
        int base = n_pkt;
        send_word(32'hE100_0ABC);
        settle();
        chk("R5 no beat for env word", n_pkt, base);
        chk("R7 status low bits from reg1", status, 13'h02BC);
        send_word(32'hE600_0003);
        settle();
        chk("R7 status high bits from reg6", status, 13'h1ABC & 13'h1FFF);
        send_word(32'hE300_07FF);
        settle();
        chk("R7 other register leaves status", status, 13'h1ABC & 13'h1FFF);
        send_word(32'hE1FF_F800);
        settle();
        chk("R5 whole word stored, low bits zero", status, 13'h1800);
        chk("R5 no beat after env words", n_pkt, base);
        exp_ptr = (exp_ptr + 4) % DEPTH;
    endtask

    task automatic t_others();
        fixed_pkt("R11 op00", 8'h00, 1, 0);
        fixed_pkt("R11 opE8", 8'hE8, 1, 0);
        fixed_pkt("R11 op40", 8'h40, 3, 0);
        fixed_pkt("R11 op6C", 8'h6C, 1, 0);
        fixed_pkt("R11 op74", 8'h74, 3, 0);
        fixed_pkt("R11 op55", 8'h55, 4, 0);
    endtask

    task automatic t_overflow();
        int base = n_pkt;
        send_word(32'h4900_0000);
        for (int i = 1; i < DEPTH; i++) send_word(32'h0000_1000 + i);
        settle();
        chk("R10 overflow pulse", n_ovf, 1);
        chk("R10 ready low during drop", m_ovf_ready, 0);
        chk("R10 no beat for dropped packet", n_pkt, base);
        fixed_pkt("R10 restart after drop", 8'h00, 1, 0);
    endtask

    task automatic t_exact_fill();
        int base = n_pkt;
        send_word(32'h4800_0000);
        for (int i = 1; i < DEPTH - 1; i++) send_word(32'h0000_1000 + i);
        send_word(32'h5000_5000);
        settle();
        chk("R10 full-size polyline no overflow", n_ovf, 1);
        expect_beat("R10 full-size polyline", base, 8'h48, DEPTH, 0, 32'h4800_0000, 32'h5000_5000);
    endtask

    task automatic t_reset_again();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R6 status cleared by reset", status, 0);
        exp_ptr = 0;
        fixed_pkt("R6 pointer restarts", 8'h20, 4, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fixed();
        t_partial();
        t_poly_every();
        t_poly_pairs();
        t_routes();
        t_env();
        t_others();
        t_overflow();
        t_exact_fill();
        t_reset_again();
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule